// File: doc/BRIEF.md
# PWM Deadtime Source Selector

This block sits between the PWM generators of a four-submodule PWM unit and its deadtime insertion stage. Each submodule owns two channels, A and B, and every channel picks one of three sources for its deadtime input: the generated PWM waveform, that waveform inverted, or a software-controlled output bit. The chosen value is registered, so each deadtime input follows its source one clock later.

The per-channel select codes are written through a single register word into a shadow copy, and a read returns that shadow copy. The shadow settings of one submodule move into that submodule's active copy only when its force-output strobe is high on a clock edge. This lets software stage a new routing for all submodules and switch each one over at a moment set by its own force event. The select word holds four bits per submodule. Submodule n uses bits [4n+1:4n] for channel A and bits [4n+3:4n+2] for channel B.

The waveform, software and force inputs are plain level signals sampled on every clock. They carry no valid/ready handshake and apply no back-pressure, because a PWM path cannot stall.

Top module: `pwm_dtsel`

## Requirements
- R1: After reset the read word is 0 and every channel output equals its generated PWM input, one cycle later.
- R2: With active code 00, a channel output equals its generated PWM input as sampled on the previous clock edge.
- R3: With active code 01, a channel output equals the inverse of its generated PWM input as sampled on the previous clock edge.
- R4: With active code 10, a channel output equals its software output bit as sampled on the previous clock edge.
- R5: Active code 11 is reserved and behaves exactly like code 00.
- R6: A register write with no force event leaves every channel's selection unchanged.
- R7: A read returns the most recently written select word in the cycle after the write, whether or not a force event has occurred.
- R8: A force event on submodule n loads only submodule n's two select fields from the shadow word. The other submodules keep their active selections.
- R9: When a write and a force event for submodule n land on the same clock edge, submodule n takes its fields from the newly written word.
- R10: The channel A and channel B select fields of a submodule act independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the select word |
| reg_wdata | input | 16 | Select word to write |
| reg_rdata | output | 16 | Shadow select word |
| force_evt | input | 4 | Force-output strobe, one bit per submodule |
| pwm_a | input | 4 | Generated PWM, channel A, one bit per submodule |
| pwm_b | input | 4 | Generated PWM, channel B, one bit per submodule |
| sw_a | input | 4 | Software output bit, channel A, per submodule |
| sw_b | input | 4 | Software output bit, channel B, per submodule |
| dt_a | output | 4 | Selected channel A signal to the deadtime stage |
| dt_b | output | 4 | Selected channel B signal to the deadtime stage |

## Verification
The bench sweeps every pair of A and B codes into every submodule, then drives all sixteen input patterns. A swapped A/B field, or a missing inversion, shows up as a wrong output bit. Every write is applied with no force first and is then forced alone on one submodule. A design that commits on the write, or that loads every submodule on any force event, changes outputs that must hold. A design that routes code 11 to the software bit or the inverse fails the reserved-code vectors. A design that forces from the stale shadow when a write and a force coincide gives the old routing on the next cycle.

// File: rtl/pwm_dtsel_pkg.sv
package pwm_dtsel_pkg;
  localparam int FIELD_W = 2;
  localparam int CHANS   = 2;
  localparam int SUB_W   = FIELD_W * CHANS;

  typedef enum logic [FIELD_W-1:0] {
    SRC_GEN = 2'b00,
    SRC_INV = 2'b01,
    SRC_SW  = 2'b10,
    SRC_RSV = 2'b11
  } src_sel_e;

  function automatic logic pick_src(input logic [FIELD_W-1:0] code,
                                    input logic gen, input logic sw);
    case (code)
      SRC_INV: return ~gen;
      SRC_SW:  return sw;
      default: return gen;
    endcase
  endfunction
endpackage

// File: rtl/pwm_dtsel_shadow.sv
module pwm_dtsel_shadow #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] shadow
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  shadow <= '0;
    else if (wr) shadow <= wdata;
  end

  assert_shadow_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (shadow == $past(wdata)));
  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(shadow));
endmodule

// File: rtl/pwm_dtsel_chan.sv
module pwm_dtsel_chan
  import pwm_dtsel_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FIELD_W-1:0] sel,
  input  logic               gen,
  input  logic               sw,
  output logic               dt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dt <= 1'b0;
    else        dt <= pick_src(sel, gen, sw);
  end

  assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b00) |=> (dt == $past(gen)));
  assert_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b01) |=> (dt == !$past(gen)));
  assert_software_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b10) |=> (dt == $past(sw)));
  assert_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |=> (dt == $past(gen)));
endmodule

// File: rtl/pwm_dtsel_sub.sv
module pwm_dtsel_sub
  import pwm_dtsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             force_evt,
  input  logic             wr,
  input  logic [SUB_W-1:0] wfield,
  input  logic [SUB_W-1:0] sfield,
  input  logic [CHANS-1:0] gen,
  input  logic [CHANS-1:0] sw,
  output logic [CHANS-1:0] dt
);
  logic [SUB_W-1:0] active;
  logic [SUB_W-1:0] commit_val;

  assign commit_val = wr ? wfield : sfield;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= '0;
    else if (force_evt) active <= commit_val;
  end

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    pwm_dtsel_chan u_chan (
      .clk  (clk),
      .rst_n(rst_n),
      .sel  (active[c*FIELD_W +: FIELD_W]),
      .gen  (gen[c]),
      .sw   (sw[c]),
      .dt   (dt[c])
    );
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !force_evt |=> $stable(active));
  assert_commit_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && !wr) |=> (active == $past(sfield)));
  assert_commit_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_evt && wr) |=> (active == $past(wfield)));
endmodule

// File: rtl/pwm_dtsel.sv
module pwm_dtsel
  import pwm_dtsel_pkg::*;
#(
  parameter int NUM_SUB = 4,
  localparam int WORD_W = NUM_SUB * SUB_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic [NUM_SUB-1:0] force_evt,
  input  logic [NUM_SUB-1:0] pwm_a,
  input  logic [NUM_SUB-1:0] pwm_b,
  input  logic [NUM_SUB-1:0] sw_a,
  input  logic [NUM_SUB-1:0] sw_b,
  output logic [NUM_SUB-1:0] dt_a,
  output logic [NUM_SUB-1:0] dt_b
);
  logic [WORD_W-1:0] shadow;

  pwm_dtsel_shadow #(.WORD_W(WORD_W)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .wdata (reg_wdata),
    .shadow(shadow)
  );

  assign reg_rdata = shadow;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    logic [CHANS-1:0] dt_s;

    pwm_dtsel_sub u_sub (
      .clk      (clk),
      .rst_n    (rst_n),
      .force_evt(force_evt[s]),
      .wr       (reg_wr),
      .wfield   (reg_wdata[s*SUB_W +: SUB_W]),
      .sfield   (shadow[s*SUB_W +: SUB_W]),
      .gen      ({pwm_b[s], pwm_a[s]}),
      .sw       ({sw_b[s], sw_a[s]}),
      .dt       (dt_s)
    );

    assign dt_a[s] = dt_s[0];
    assign dt_b[s] = dt_s[1];
  end
endmodule

// File: tb/test_pwm_dtsel.sv
module test_pwm_dtsel;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  force_evt = '0;
  logic [3:0]  pwm_a = '0, pwm_b = '0, sw_a = '0, sw_b = '0;
  logic [3:0]  dt_a, dt_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [15:0] m_shadow = '0;
  logic [1:0]  m_act [NS][2];

  always #5 clk = ~clk;

  pwm_dtsel i_pwm_dtsel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .force_evt(force_evt), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .sw_a(sw_a), .sw_b(sw_b), .dt_a(dt_a), .dt_b(dt_b)
  );

  function automatic logic model(input logic [1:0] code, input logic g, input logic s);
    if (code == 2'd1) return !g;
    if (code == 2'd2) return s;
    return g;
  endfunction

  function automatic string code_tag(input logic [1:0] code);
    case (code)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp, input string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  // one clock: apply inputs, predict from the bench model, compare after the edge
  task automatic step(input logic wr, input logic [15:0] wd, input logic [3:0] frc,
                      input logic [3:0] pa, input logic [3:0] pb,
                      input logic [3:0] sa, input logic [3:0] sb, input string tag);
    logic [3:0] ea, eb;
    @(negedge clk);
    reg_wr = wr; reg_wdata = wd; force_evt = frc;
    pwm_a = pa; pwm_b = pb; sw_a = sa; sw_b = sb;
    for (int s = 0; s < NS; s++) begin
      ea[s] = model(m_act[s][0], pa[s], sa[s]);
      eb[s] = model(m_act[s][1], pb[s], sb[s]);
    end
    if (wr) m_shadow = wd;
    for (int s = 0; s < NS; s++)
      if (frc[s]) begin
        m_act[s][0] = m_shadow[4*s +: 2];
        m_act[s][1] = m_shadow[4*s+2 +: 2];
      end
    @(posedge clk);
    #1;
    for (int s = 0; s < NS; s++) begin
      check((tag != "") ? tag : code_tag(reg_rdata[0] === 1'bx ? 2'd0 : m_act[s][0]),
            {15'd0, dt_a[s]}, {15'd0, ea[s]}, $sformatf("dt_a[%0d]", s));
      check((tag != "") ? tag : code_tag(m_act[s][1]),
            {15'd0, dt_b[s]}, {15'd0, eb[s]}, $sformatf("dt_b[%0d]", s));
    end
    check((tag != "") ? tag : "R7", reg_rdata, m_shadow, "reg_rdata");
    reg_wr = 1'b0; force_evt = '0;
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_act[s][0] = 2'd0;
      m_act[s][1] = 2'd0;
    end
    repeat (3) @(posedge clk);
    #1;
    check("R1", reg_rdata, 16'h0000, "reg_rdata in reset");
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset selection passes the generated signals
    for (int v = 0; v < 16; v++)
      step(1'b0, '0, '0, v[3:0], ~v[3:0], v[3:0] ^ 4'hA, 4'h3, "R1");

    for (int s = 0; s < NS; s++)
      for (int ca = 0; ca < 4; ca++)
        for (int cb = 0; cb < 4; cb++) begin
          logic [15:0] w;
          w = 16'((s * 16 + ca * 4 + cb) * 16'h9E37);
          w[4*s +: 4] = {cb[1:0], ca[1:0]};
          // R6 / R7: write only, nothing may change at the outputs
          step(1'b1, w, 4'h0, 4'h5, 4'hA, 4'hC, 4'h3, "R6");
          // R8: force one submodule only
          step(1'b0, '0, 4'(1 << s), 4'h9, 4'h6, 4'h0, 4'hF, "R8");
          for (int v = 0; v < 16; v++)
            step(1'b0, '0, '0, v[3:0], v[3:0] ^ 4'h5, ~v[3:0], {v[1:0], v[3:2]}, "");
        end

    // R9: write and force on the same edge
    step(1'b1, 16'h0000, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, "R9");
    step(1'b1, 16'h5555, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, "R6");
    step(1'b1, 16'h9999, 4'h5, 4'h0, 4'h0, 4'hF, 4'hF, "R9");
    for (int v = 0; v < 4; v++)
      step(1'b0, '0, '0, v[3:0], ~v[3:0], 4'hF, 4'h0, "R9");

    // R10: A inverts, B takes software, in every submodule
    step(1'b1, 16'h9999, 4'hF, 4'h0, 4'h0, 4'h0, 4'h0, "R10");
    step(1'b0, '0, '0, 4'h3, 4'h3, 4'h0, 4'h5, "R10");
    step(1'b0, '0, '0, 4'hC, 4'h3, 4'hF, 4'hA, "R10");
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule